// File: doc/BRIEF.md
# Free Address List Manager

This block keeps track of which slots in a shared cell memory are unused. After a synchronous reset it walks through every slot index, one per clock, and places each index into an internal first-in first-out list. When that walk is over it raises `ready`. From then on it hands out one unused slot index each time a storing agent asks for one, and it takes indices back when cells leave the memory, so they can be handed out again.

A grant is combinational. In the cycle `alloc_req` is high, `alloc_valid` and `alloc_addr` answer in that same cycle, and the list is updated at the next clock edge. If no slot is left, the request is refused and counted as a dropped cell. When the list is empty and a slot is returned in the same cycle as a request, the returned index goes straight to the requester. A return made while every slot is already free is a fault. It is flagged and discarded.

Top module: `freelist_mgr`

## Requirements
- R1: After reset `ready` is low. The list is loaded with the indices 0, 1, …, DEPTH-1, one per clock. `ready` rises after exactly DEPTH rising edges counted from the first edge with reset low. At that point `free_cnt` equals DEPTH, and `ready` then stays high.
- R2: While `ready` is low, `alloc_valid` stays low and a request does not change `drop_count`.
- R3: A granted request returns the oldest index in the list. Right after the initial walk, the grants come out in ascending order starting from 0.
- R4: A return accepted while the list is not full appends `rel_addr` to the tail of the list and raises `free_cnt` by one.
- R5: When the list is empty and no return arrives in the same cycle, a request gets `alloc_valid` low. `drop_count` then rises by one, and it saturates at its maximum value.
- R6: A request and a return in the same cycle, with the list neither empty nor full, are both serviced and `free_cnt` is unchanged.
- R7: When the list is empty, a request and a return in the same cycle give `alloc_valid` high with `alloc_addr` equal to `rel_addr`. `free_cnt` stays 0 and `drop_count` is unchanged.
- R8: A return made while `full` is high drives `rel_err` high in that cycle. The index is not stored and `free_cnt` does not grow.
- R9: `empty` is high exactly when `free_cnt` is 0. `full` is high exactly when `free_cnt` equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request for one free slot index |
| alloc_valid | output | 1 | Grant for the current request |
| alloc_addr | output | AW | Granted slot index |
| rel_valid | input | 1 | A slot index is being returned |
| rel_addr | input | AW | Returned slot index |
| ready | output | 1 | Initial walk finished |
| empty | output | 1 | No free index left |
| full | output | 1 | All indices free |
| rel_err | output | 1 | Return refused because the list is full |
| free_cnt | output | AW+1 | Number of free indices held |
| drop_count | output | DROP_W | Requests refused on an empty list, saturating |

## Verification
The grant path is driven with several patterns. A full drain right after the walk shows the initial loading order. A refill in descending order shows that returned indices keep their return order and are not re-sorted. An interleaved sequence of returns, with one simultaneous request and return, separates a correct tail append from a count that drifts. Requests on an empty list, with and without a same-cycle return, separate the drop path from the forwarding path. A return on a full list is followed by a complete drain and one further request, which shows whether the refused index leaked into storage.

// File: rtl/fl_pkg.sv
package fl_pkg;

    typedef enum logic {
        ST_WALK = 1'b0,
        ST_RUN  = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic push;
        logic pop;
    } list_op_t;

    // Circular index advance for a list of arbitrary depth
    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/fl_walker.sv
module fl_walker
    import fl_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          gen_push,
    output logic [AW-1:0] gen_addr,
    output logic          walk_done
);

    walk_state_e   state;
    logic [AW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WALK;
            idx   <= '0;
        end else if (state == ST_WALK) begin
            if (idx == AW'(DEPTH - 1)) state <= ST_RUN;
            idx <= AW'(wrap_next(32'(idx), DEPTH));
        end
    end

    assign gen_push  = (state == ST_WALK);
    assign gen_addr  = idx;
    assign walk_done = (state == ST_RUN);

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> walk_done); // R1

endmodule

// File: rtl/fl_list.sv
module fl_list
    import fl_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  list_op_t      op,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] head,
    output logic [CW-1:0] count
);

    logic [AW-1:0] slots [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (op.push) slots[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (op.push) wr_ptr <= AW'(wrap_next(32'(wr_ptr), DEPTH));
            if (op.pop)  rd_ptr <= AW'(wrap_next(32'(rd_ptr), DEPTH));
            case ({op.push, op.pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = slots[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (op.push && !op.pop) |-> (count < CW'(DEPTH))); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        op.pop |-> (count != '0)); // R5

endmodule

// File: rtl/freelist_mgr.sv
module freelist_mgr
    import fl_pkg::*;
#(
    parameter  int DEPTH  = 256,
    parameter  int DROP_W = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    output logic              alloc_valid,
    output logic [AW-1:0]     alloc_addr,
    input  logic              rel_valid,
    input  logic [AW-1:0]     rel_addr,
    output logic              ready,
    output logic              empty,
    output logic              full,
    output logic              rel_err,
    output logic [CW-1:0]     free_cnt,
    output logic [DROP_W-1:0] drop_count
);

    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    logic          gen_push;
    logic [AW-1:0] gen_addr;
    logic [AW-1:0] head;
    logic [CW-1:0] count;
    list_op_t      op;
    logic          rel_take, fwd, grant_pop, rel_store, refuse;

    fl_walker #(.DEPTH(DEPTH), .AW(AW)) u_walker (
        .clk(clk), .rst(rst),
        .gen_push(gen_push), .gen_addr(gen_addr), .walk_done(ready)
    );

    always_comb begin
        rel_take  = ready && rel_valid;
        fwd       = ready && alloc_req && empty && rel_valid;
        grant_pop = ready && alloc_req && !empty;
        rel_err   = rel_take && full;
        rel_store = rel_take && !full && !fwd;
        refuse    = ready && alloc_req && empty && !rel_valid;
        op.push   = gen_push || rel_store;
        op.pop    = grant_pop;
    end

    fl_list #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_list (
        .clk(clk), .rst(rst), .op(op),
        .wr_data(gen_push ? gen_addr : rel_addr),
        .head(head), .count(count)
    );

    assign empty       = (count == '0);
    assign full        = (count == CW'(DEPTH));
    assign free_cnt    = count;
    assign alloc_valid = grant_pop || fwd;
    assign alloc_addr  = fwd ? rel_addr : head;

    always_ff @(posedge clk) begin
        if (rst)                                drop_count <= '0;
        else if (refuse && drop_count != DROP_MAX) drop_count <= drop_count + 1'b1;
    end

    AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> ready); // R2
    AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (ready && alloc_req && rel_valid && !full) |=> $stable(free_cnt)); // R6
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
        (ready && alloc_req && free_cnt == '0 && !rel_valid && drop_count != DROP_MAX)
        |=> drop_count == $past(drop_count) + 1'b1); // R5
    AST_FULL_RETURN_DISCARDED: assert property (@(posedge clk) disable iff (rst)
        (rel_err && !alloc_req) |=> $stable(free_cnt)); // R8
    AST_NOT_READY_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(drop_count)); // R2

endmodule

// File: tb/freelist_mgr_test.sv
module freelist_mgr_test;

    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_req = 1'b0;
    logic rel_valid = 1'b0;
    logic [AW-1:0] rel_addr = '0;
    logic alloc_valid, ready, empty, full, rel_err;
    logic [AW-1:0] alloc_addr;
    logic [CW-1:0] free_cnt;
    logic [15:0] drop_count;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    freelist_mgr #(.DEPTH(DEPTH), .DROP_W(16)) uut (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .rel_valid(rel_valid), .rel_addr(rel_addr),
        .ready(ready), .empty(empty), .full(full), .rel_err(rel_err),
        .free_cnt(free_cnt), .drop_count(drop_count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus; combinational answers captured before the edge
    task automatic op(input logic a, input logic r, input int ra,
                      output logic v, output int ad, output logic er);
        @(negedge clk);
        alloc_req = a;
        rel_valid = r;
        rel_addr  = AW'(ra);
        #1;
        v  = alloc_valid;
        ad = int'(alloc_addr);
        er = rel_err;
        @(posedge clk);
        #1;
        alloc_req = 1'b0;
        rel_valid = 1'b0;
    endtask

    task automatic t_init();
        int n = 0;
        alloc_req = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4 * DEPTH; i++) begin
            @(negedge clk);
            #1;
            n++;
            if (ready) begin
                alloc_req = 1'b0;
                break;
            end
            if (alloc_valid) check("R2 grant during walk", 1, 0);
        end
        check("R1 walk length", n, DEPTH);
        @(negedge clk);
        check("R1 free count after walk", int'(free_cnt), DEPTH);
        check("R9 full after walk", int'(full), 1);
        check("R9 empty after walk", int'(empty), 0);
        check("R2 no drops during walk", int'(drop_count), 0);
    endtask

    task automatic t_drain();
        logic v, e; int ad;
        for (int i = 0; i < DEPTH; i++) begin
            op(1'b1, 1'b0, 0, v, ad, e);
            check("R3 grant valid", int'(v), 1);
            check("R3 ascending order", ad, i);
        end
        @(negedge clk);
        check("R9 empty after drain", int'(empty), 1);
        check("R9 count zero", int'(free_cnt), 0);
    endtask

    task automatic t_drop();
        logic v, e; int ad;
        for (int i = 0; i < 3; i++) begin
            op(1'b1, 1'b0, 0, v, ad, e);
            check("R5 refused on empty", int'(v), 0);
        end
        @(negedge clk);
        check("R5 drop count", int'(drop_count), 3);
    endtask

    task automatic t_forward();
        logic v, e; int ad;
        op(1'b1, 1'b1, 5, v, ad, e);
        check("R7 forward valid", int'(v), 1);
        check("R7 forward address", ad, 5);
        @(negedge clk);
        check("R7 count stays zero", int'(free_cnt), 0);
        check("R7 no drop", int'(drop_count), 3);
    endtask

    task automatic t_mixed();
        logic v, e; int ad;
        op(1'b0, 1'b1, 3, v, ad, e);
        op(1'b0, 1'b1, 7, v, ad, e);
        op(1'b0, 1'b1, 9, v, ad, e);
        @(negedge clk);
        check("R4 count after returns", int'(free_cnt), 3);
        op(1'b1, 1'b1, 11, v, ad, e);
        check("R6 swap grant", ad, 3);
        @(negedge clk);
        check("R6 count unchanged", int'(free_cnt), 3);
        op(1'b1, 1'b0, 0, v, ad, e); check("R4 tail order a", ad, 7);
        op(1'b1, 1'b0, 0, v, ad, e); check("R4 tail order b", ad, 9);
        op(1'b1, 1'b0, 0, v, ad, e); check("R4 tail order c", ad, 11);
        @(negedge clk);
        check("R9 empty again", int'(empty), 1);
    endtask

    task automatic t_full_err();
        logic v, e; int ad;
        for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, DEPTH - 1 - i, v, ad, e);
        @(negedge clk);
        check("R9 full after refill", int'(full), 1);
        op(1'b0, 1'b1, 10, v, ad, e);
        check("R8 error flag", int'(e), 1);
        @(negedge clk);
        check("R8 count not grown", int'(free_cnt), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            op(1'b1, 1'b0, 0, v, ad, e);
            check("R4 refill order", ad, DEPTH - 1 - i);
        end
        op(1'b1, 1'b0, 0, v, ad, e);
        check("R8 refused index not stored", int'(v), 0);
        @(negedge clk);
        check("R5 drop after drain", int'(drop_count), 4);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_init();
        t_drain();
        t_drop();
        t_forward();
        t_mixed();
        t_full_err();
        summary();
    end

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule